// File: doc/BRIEF.md
# Per-Line Auxiliary Panel Strobe Generator

This block drives four auxiliary control strobes that some TFT panels need once per line: a source-latch strobe, a gate-clock strobe, a polarity strobe and an inversion strobe. It does not run its own pixel counter. It takes the horizontal pixel count and a last-pixel flag from the display timing generator, and it compares the count against a programmed start/end window for each strobe. It drives each strobe at a configurable active level.

A window may end past the line total. In that case the strobe stays asserted across the line boundary and is released on the following line, once the counter reaches the end minus the line total. A line that continues a carried window does not start that window again. A window programmed as start to start plus the line total therefore stays active for one whole line and inactive for the next, which gives a strobe that toggles at line rate.

Each strobe is registered. It reflects the counter value seen on the previous clock, so it has one cycle of latency behind the counter.

Top module: `auxpulse_gen`

## Requirements
- R1: While the active-low reset is asserted, every strobe is at its inactive level, and no window is carried into the first line after reset.
- R2: Each window port holds the start position in its upper half (bits 2*CW-1 down to CW) and the end position in its lower half (bits CW-1 down to 0).
- R3: In a line that does not continue a carried window, a strobe with start below end is active in the cycle after each counter value c with start <= c < end, and inactive otherwise.
- R4: A strobe whose start equals its end is never active and never carries into the next line. The same holds in a normal line when start is greater than end.
- R5: The line-last flag marks the cycle in which the counter holds lineTotal-1. When a normal line holds a window with start < lineTotal and end > lineTotal, the next line is a continuation line for that strobe. In a continuation line the strobe is active after each counter value c < end - lineTotal.
- R6: A continuation line never arms a further carry and never restarts the window. A window with end = start + lineTotal is therefore active for one full line and then inactive for one full line.
- R7: The activeHigh bit of each strobe selects its level: 1 drives the strobe high when active, and 0 drives it low when active. Bit 0 is latch, bit 1 is gate, bit 2 is polarity and bit 3 is inversion.
- R8: The four strobes are computed independently, each from its own window port, in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hCount | input | CW | Horizontal pixel counter from the timing generator |
| lineWrap | input | 1 | High while hCount holds the last pixel of a line |
| lineTotal | input | CW | Pixel clocks per line |
| latchWin | input | 2*CW | Source-latch window {start, end} |
| gateWin | input | 2*CW | Gate-clock window {start, end} |
| polWin | input | 2*CW | Polarity window {start, end} |
| invWin | input | 2*CW | Inversion window {start, end} |
| activeHigh | input | 4 | Per-strobe level select |
| latchOut | output | 1 | Source-latch strobe |
| gateOut | output | 1 | Gate-clock strobe |
| polOut | output | 1 | Polarity strobe |
| invOut | output | 1 | Inversion strobe |

## Verification
Two things can fall in the same cycle. One is the end of a carried tail in a continuation line. The other is the counter reaching the window's own start, which must not restart the window. For a window programmed as start to start plus total, both land on the same counter value. The sweep also sets starts at the last pixel of the line, so that a start coincides with the line-last flag. The bench runs every start/end pair on a small line for several lines. It judges each cycle against a line-by-line arithmetic model that decides continuation from the previous line's window alone.

// File: rtl/auxpulse_pkg.sv
package auxpulse_pkg;
  parameter int unsigned AP_CH = 4;

  // strobes from control to datapath, one bit per channel
  typedef struct packed {
    logic [AP_CH-1:0] carryLine;  // current line continues a carried window
    logic [AP_CH-1:0] quiet;      // start equals end: channel held off
  } apStrobe_t;
endpackage

// File: rtl/auxpulse_ctrl.sv
module auxpulse_ctrl
  import auxpulse_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      lineWrap,
  input  logic [CW-1:0]             lineTotal,
  input  logic [AP_CH-1:0][CW-1:0]  winStart,
  input  logic [AP_CH-1:0][CW-1:0]  winEnd,
  output apStrobe_t                 strobe
);
  logic [AP_CH-1:0] carryQ;
  logic [AP_CH-1:0] quietV;
  logic [AP_CH-1:0] armV;

  for (genvar k = 0; k < AP_CH; k++) begin : g_ch
    assign quietV[k] = (winStart[k] == winEnd[k]);
    // window starts inside this line and runs beyond its end
    assign armV[k]   = !quietV[k] && (winStart[k] < lineTotal) && (winEnd[k] > lineTotal);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         carryQ[k] <= 1'b0;
      else if (lineWrap) carryQ[k] <= !carryQ[k] && armV[k];
    end

    AST_CARRY_ALTERNATES: assert property (@(posedge clk) disable iff (!rstN)
      (lineWrap && carryQ[k]) |=> !carryQ[k]); // R6
    AST_QUIET_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
      (lineWrap && quietV[k]) |=> !carryQ[k]); // R4
  end

  AST_CARRY_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !lineWrap |=> $stable(carryQ)); // R5

  assign strobe.carryLine = carryQ;
  assign strobe.quiet     = quietV;
endmodule

// File: rtl/auxpulse_dp.sv
module auxpulse_dp
  import auxpulse_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [CW-1:0]             hCount,
  input  logic [CW-1:0]             lineTotal,
  input  logic [AP_CH-1:0][CW-1:0]  winStart,
  input  logic [AP_CH-1:0][CW-1:0]  winEnd,
  input  logic [AP_CH-1:0]          activeHigh,
  input  apStrobe_t                 strobe,
  output logic [AP_CH-1:0]          pinOut
);
  localparam int unsigned XW = CW + 1;

  logic [AP_CH-1:0] onQ;
  logic [AP_CH-1:0] inWin;

  for (genvar k = 0; k < AP_CH; k++) begin : g_ch
    logic [XW-1:0] tail;     // carried length into the continuation line
    logic          inLine;
    logic          inTail;

    assign tail   = {1'b0, winEnd[k]} - {1'b0, lineTotal};
    assign inLine = (hCount >= winStart[k]) && (hCount < winEnd[k]);
    assign inTail = (winEnd[k] > lineTotal) && ({1'b0, hCount} < tail);
    assign inWin[k] = !strobe.quiet[k] && (strobe.carryLine[k] ? inTail : inLine);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) onQ[k] <= 1'b0;
      else       onQ[k] <= inWin[k];
    end

    assign pinOut[k] = activeHigh[k] ? onQ[k] : !onQ[k];

    AST_QUIET_STAYS_OFF: assert property (@(posedge clk) disable iff (!rstN)
      (winStart[k] == winEnd[k]) |=> !onQ[k]); // R4
    AST_START_ASSERTS: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.carryLine[k] && hCount == winStart[k] && winStart[k] < winEnd[k]) |=> onQ[k]); // R3
    AST_TAIL_ENDS: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.carryLine[k] && {1'b0, hCount} == tail) |=> !onQ[k]); // R5
  end
endmodule

// File: rtl/auxpulse_gen.sv
module auxpulse_gen
  import auxpulse_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CW-1:0]   hCount,
  input  logic            lineWrap,
  input  logic [CW-1:0]   lineTotal,
  input  logic [2*CW-1:0] latchWin,
  input  logic [2*CW-1:0] gateWin,
  input  logic [2*CW-1:0] polWin,
  input  logic [2*CW-1:0] invWin,
  input  logic [3:0]      activeHigh,
  output logic            latchOut,
  output logic            gateOut,
  output logic            polOut,
  output logic            invOut
);
  logic [AP_CH-1:0][2*CW-1:0] winAll;
  logic [AP_CH-1:0][CW-1:0]   winStart;
  logic [AP_CH-1:0][CW-1:0]   winEnd;
  logic [AP_CH-1:0]           pinOut;
  apStrobe_t                  strobe;

  assign winAll = {invWin, polWin, gateWin, latchWin};

  for (genvar k = 0; k < AP_CH; k++) begin : g_split
    assign winStart[k] = winAll[k][2*CW-1:CW];
    assign winEnd[k]   = winAll[k][CW-1:0];
  end

  auxpulse_ctrl #(.CW(CW)) i_ctrl (
    .clk(clk), .rstN(rstN), .lineWrap(lineWrap), .lineTotal(lineTotal),
    .winStart(winStart), .winEnd(winEnd), .strobe(strobe)
  );

  auxpulse_dp #(.CW(CW)) i_dp (
    .clk(clk), .rstN(rstN), .hCount(hCount), .lineTotal(lineTotal),
    .winStart(winStart), .winEnd(winEnd), .activeHigh(activeHigh),
    .strobe(strobe), .pinOut(pinOut)
  );

  assign latchOut = pinOut[0];
  assign gateOut  = pinOut[1];
  assign polOut   = pinOut[2];
  assign invOut   = pinOut[3];
endmodule

// File: tb/test_auxpulse_gen.sv
module test_auxpulse_gen;
  localparam int CW = 16;
  localparam int T  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] hCount = '0;
  logic lineWrap = 1'b0;
  logic [CW-1:0] lineTotal = CW'(T);
  logic [2*CW-1:0] latchWin = '0, gateWin = '0, polWin = '0, invWin = '0;
  logic [3:0] activeHigh = 4'hF;
  logic latchOut, gateOut, polOut, invOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  int  ws [4];
  int  we [4];
  bit  cont [4];
  bit  expPin [4];
  string expTag [4];
  bit  expValid = 0;

  always #2 clk = ~clk;  // 250 MHz

  auxpulse_gen #(.CW(CW)) i_auxpulse_gen (
    .clk(clk), .rstN(rstN), .hCount(hCount), .lineWrap(lineWrap), .lineTotal(lineTotal),
    .latchWin(latchWin), .gateWin(gateWin), .polWin(polWin), .invWin(invWin),
    .activeHigh(activeHigh), .latchOut(latchOut), .gateOut(gateOut),
    .polOut(polOut), .invOut(invOut)
  );

  function automatic bit pinOf(int k);
    case (k)
      0: return latchOut;
      1: return gateOut;
      2: return polOut;
      default: return invOut;
    endcase
  endfunction

  task automatic check(string tag, int k, bit got, bit exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s ch%0d hCount=%0d got %b expected %b", tag, k, hCount, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  // one pixel: check the outputs produced by the previous count, then drive the next
  task automatic step(int c);
    @(negedge clk);
    if (expValid)
      for (int k = 0; k < 4; k++) check(expTag[k], k, pinOf(k), expPin[k]);
    hCount   = CW'(c);
    lineWrap = (c == T - 1);
    for (int k = 0; k < 4; k++) begin
      bit raw;
      if (ws[k] == we[k]) begin
        raw = 0; expTag[k] = "R4";
      end else if (cont[k]) begin
        raw = (c + T < we[k]);  // R5 tail of carried window
        expTag[k] = (we[k] == ws[k] + T) ? "R6" : "R5";
      end else begin
        raw = (c >= ws[k]) && (c < we[k]);  // R3
        expTag[k] = (ws[k] > we[k]) ? "R4" : "R3";
      end
      if (!activeHigh[k]) expTag[k] = {expTag[k], " R7"};
      expPin[k] = activeHigh[k] ? raw : !raw;
    end
    if (c == T - 1)
      for (int k = 0; k < 4; k++)
        cont[k] = !cont[k] && (ws[k] != we[k]) && (ws[k] < T) && (we[k] > T);
    expValid = 1;
  endtask

  initial begin
    for (int s = 0; s < T; s++) begin
      for (int e = 0; e <= 2 * T; e++) begin
        int idx;
        idx = s * (2 * T + 1) + e;
        @(negedge clk);
        rstN = 1'b0;
        // R8: four independent windows; R2: start in upper half, end in lower half
        ws[0] = s;             we[0] = e;
        ws[1] = (s + 3) % T;   we[1] = (e + 7) % (2 * T + 1);
        ws[2] = s;             we[2] = s + T;
        ws[3] = e % T;         we[3] = s;
        latchWin = {CW'(ws[0]), CW'(we[0])};
        gateWin  = {CW'(ws[1]), CW'(we[1])};
        polWin   = {CW'(ws[2]), CW'(we[2])};
        invWin   = {CW'(ws[3]), CW'(we[3])};
        activeHigh = 4'(idx) ^ 4'b0101;
        for (int k = 0; k < 4; k++) cont[k] = 0;
        expValid = 0;
        hCount = '0;
        lineWrap = 1'b0;
        @(negedge clk);
        // R1: inactive level during reset
        for (int k = 0; k < 4; k++) check("R1", k, pinOf(k), !activeHigh[k]);
        rstN = 1'b1;
        for (int ln = 0; ln < 4; ln++)
          for (int c = 0; c < T; c++) step(c);
        @(negedge clk);
        for (int k = 0; k < 4; k++) check(expTag[k], k, pinOf(k), expPin[k]);
        expValid = 0;
      end
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule